// File: doc/BRIEF.md
# Multiport Repeater Arbitration Core

This block is the control core of a five-port 100 Mb/s repeater. On every clock it looks at the carrier sense and receive-data-valid inputs of all ports and decides what the repeater does next: stay quiet, forward the nibbles of the one port that is receiving, or flood the segment with a jam pattern. The result is a set of per-port transmit enables and one shared transmit nibble. That nibble is either the active port's receive nibble or the jam value 0x5.

Jabber and partition supervision are outside the block. Their verdicts arrive as two per-port flag vectors. A flagged port neither counts as a carrier source nor receives transmit enable. The block also reports each cycle which ports took part in the current collision, so that an external partition counter can use it.

All outputs are registered. Each output value reflects the inputs sampled at the previous rising clock edge.

Top module: `rptr_core`

## Requirements
- R1: While reset is low, and afterwards whenever no usable port carrier is present, the state code is 0 (idle) and tx_en, txd and col_part are all zero.
- R2: When exactly one usable port p asserts carrier, the next cycle shows state code 1 (forward). tx_en is then high on every usable port except p, and txd equals p's nibble rxd[4p+3:4p] as sampled on the previous cycle.
- R3: A port whose jabber or isolate flag is high is treated as having no carrier, and its tx_en stays low in every state.
- R4: When two or more usable ports assert carrier in the same cycle, the next cycle shows state code 2 (collision), tx_en high on every usable port, and txd = 0x5.
- R5: A lone carrier whose receive-data-valid stays low for more than 4 consecutive sampled cycles causes collision (state code 2) after the fifth such cycle. A run of four low cycles followed by valid data stays in forward.
- R6: From collision, when exactly one usable port still has carrier, the next state is code 3 (one port left). In that state tx_en is high on every usable port except that port, and txd = 0x5 whatever rxd carries.
- R7: In the one-port-left state, loss of all carrier returns to idle. Any carrier pattern other than the remaining port alone returns to collision.
- R8: col_part holds the OR of every usable port that had carrier in any cycle decided as collision. It is held through one-port-left and is zero in idle and forward.
- R9: In forward, loss of carrier returns the block to idle on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crs | input | NPORT | Per-port carrier sense |
| rxdv | input | NPORT | Per-port receive data valid |
| rxd | input | 4*NPORT | Per-port receive nibbles, port p at bits 4p+3:4p |
| jab | input | NPORT | Per-port jabber verdict |
| iso | input | NPORT | Per-port isolate/partition verdict |
| tx_en | output | NPORT | Per-port transmit enable |
| txd | output | 4 | Shared transmit nibble |
| col_part | output | NPORT | Per-port collision participation |
| state_o | output | 2 | 0 idle, 1 forward, 2 collision, 3 one port left |

## Verification
Every result is due exactly one clock after the inputs that cause it, because state, enables, nibble and participation are all captured at the same edge. The only exception is the data-valid timeout, which needs five consecutive sampled cycles before the collision appears on the following edge. The driver applies inputs on the falling edge and pushes the expected outputs for that step. The monitor pops them a quarter period after the next rising edge, so each comparison lands in the cycle when the registered outputs have just settled.

// File: rtl/rptr_pkg.sv
package rptr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FWD  = 2'd1,
    ST_COL  = 2'd2,
    ST_OPL  = 2'd3
  } rstate_t;

  localparam logic [3:0] JAM_NIB = 4'h5;

  // number of set bits
  function automatic int unsigned pop32(input logic [31:0] v);
    int unsigned c;
    c = 0;
    for (int b = 0; b < 32; b++) if (v[b]) c++;
    return c;
  endfunction

  // index of the lowest set bit (0 when none)
  function automatic int unsigned first_set(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int b = 31; b >= 0; b--) if (v[b]) r = b;
    return r;
  endfunction

endpackage

// File: rtl/rptr_scan.sv
module rptr_scan #(
  parameter int NPORT = 5,
  parameter int IDXW  = 3
) (
  input  logic [NPORT-1:0] crs,
  input  logic [NPORT-1:0] excl,
  output logic [NPORT-1:0] act,
  output logic             none,
  output logic             single,
  output logic             multi,
  output logic [IDXW-1:0]  idx
);
  import rptr_pkg::*;

  int unsigned cnt;

  assign act    = crs & ~excl;
  assign cnt    = pop32(32'(act));
  assign none   = (cnt == 0);
  assign single = (cnt == 1);
  assign multi  = (cnt >= 2);
  assign idx    = IDXW'(first_set(32'(act)));
endmodule

// File: rtl/rptr_dv_watch.sv
module rptr_dv_watch #(
  parameter int NPORT    = 5,
  parameter int IDXW     = 3,
  parameter int DV_LIMIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval,
  input  logic             in_fwd,
  input  logic             single,
  input  logic [IDXW-1:0]  idx,
  input  logic [IDXW-1:0]  src,
  input  logic [NPORT-1:0] rxdv,
  output logic             timeout
);
  localparam int CW = $clog2(DV_LIMIT + 2);

  logic [CW-1:0] low_q, low_nx;
  logic          dv_now, cont;

  assign dv_now = rxdv[idx];
  assign cont   = in_fwd && (idx == src);

  always_comb begin
    if (dv_now)    low_nx = '0;
    else if (cont) low_nx = low_q + CW'(1);
    else           low_nx = CW'(1);
  end

  assign timeout = eval && single && !dv_now && (low_nx > CW'(DV_LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n)                         low_q <= '0;
    else if (eval && single && !timeout) low_q <= low_nx;
    else                                low_q <= '0;
  end
endmodule

// File: rtl/rptr_tx_out.sv
module rptr_tx_out #(
  parameter int NPORT = 5,
  parameter int IDXW  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  rptr_pkg::rstate_t  st_nx,
  input  logic [IDXW-1:0]    src_nx,
  input  logic [IDXW-1:0]    left_nx,
  input  logic [4*NPORT-1:0] rxd,
  input  logic [NPORT-1:0]   excl,
  input  logic [NPORT-1:0]   act,
  output logic [NPORT-1:0]   tx_en,
  output logic [3:0]         txd,
  output logic [NPORT-1:0]   col_part
);
  import rptr_pkg::*;

  localparam logic [NPORT-1:0] ONE = NPORT'(1);

  logic [3:0]       nib [NPORT];
  logic [NPORT-1:0] en_nx, part_nx;
  logic [3:0]       txd_nx;

  for (genvar g = 0; g < NPORT; g++) begin : g_nib
    assign nib[g] = rxd[4*g +: 4];
  end

  always_comb begin
    en_nx   = '0;
    txd_nx  = '0;
    part_nx = '0;
    case (st_nx)
      ST_FWD: begin
        en_nx  = ~excl & ~(ONE << src_nx);
        txd_nx = nib[src_nx];
      end
      ST_COL: begin
        en_nx   = ~excl;
        txd_nx  = JAM_NIB;
        part_nx = col_part | act;
      end
      ST_OPL: begin
        en_nx   = ~excl & ~(ONE << left_nx);
        txd_nx  = JAM_NIB;
        part_nx = col_part;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_en    <= '0;
      txd      <= '0;
      col_part <= '0;
    end else begin
      tx_en    <= en_nx;
      txd      <= txd_nx;
      col_part <= part_nx;
    end
  end
endmodule

// File: rtl/rptr_core.sv
module rptr_core #(
  parameter int NPORT    = 5,
  parameter int DV_LIMIT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPORT-1:0]   crs,
  input  logic [NPORT-1:0]   rxdv,
  input  logic [4*NPORT-1:0] rxd,
  input  logic [NPORT-1:0]   jab,
  input  logic [NPORT-1:0]   iso,
  output logic [NPORT-1:0]   tx_en,
  output logic [3:0]         txd,
  output logic [NPORT-1:0]   col_part,
  output logic [1:0]         state_o
);
  import rptr_pkg::*;

  localparam int IDXW = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam logic [NPORT-1:0] ONE = NPORT'(1);

  rstate_t          state_q, st_nx;
  logic [IDXW-1:0]  src_q, src_nx, left_q, left_nx, idx;
  logic [NPORT-1:0] excl, act;
  logic             none, single, multi, dv_to;

  assign excl = jab | iso;

  rptr_scan #(.NPORT(NPORT), .IDXW(IDXW)) u_scan (
    .crs(crs), .excl(excl), .act(act), .none(none),
    .single(single), .multi(multi), .idx(idx)
  );

  rptr_dv_watch #(.NPORT(NPORT), .IDXW(IDXW), .DV_LIMIT(DV_LIMIT)) u_dv (
    .clk(clk), .rst_n(rst_n),
    .eval((state_q == ST_IDLE) || (state_q == ST_FWD)),
    .in_fwd(state_q == ST_FWD), .single(single), .idx(idx),
    .src(src_q), .rxdv(rxdv), .timeout(dv_to)
  );

  always_comb begin
    st_nx   = state_q;
    src_nx  = src_q;
    left_nx = left_q;
    case (state_q)
      ST_IDLE, ST_FWD: begin
        if (none)               st_nx = ST_IDLE;
        else if (multi || dv_to) st_nx = ST_COL;
        else begin
          st_nx  = ST_FWD;
          src_nx = idx;
        end
      end
      ST_COL: begin
        if (none) st_nx = ST_IDLE;
        else if (single) begin
          st_nx   = ST_OPL;
          left_nx = idx;
        end else  st_nx = ST_COL;
      end
      ST_OPL: begin
        if (act == (ONE << left_q)) st_nx = ST_OPL;
        else if (none)              st_nx = ST_IDLE;
        else                        st_nx = ST_COL;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      left_q  <= '0;
    end else begin
      state_q <= st_nx;
      src_q   <= src_nx;
      left_q  <= left_nx;
    end
  end

  rptr_tx_out #(.NPORT(NPORT), .IDXW(IDXW)) u_tx (
    .clk(clk), .rst_n(rst_n), .st_nx(st_nx), .src_nx(src_nx),
    .left_nx(left_nx), .rxd(rxd), .excl(excl), .act(act),
    .tx_en(tx_en), .txd(txd), .col_part(col_part)
  );

  assign state_o = state_q;
endmodule

// File: rtl/rptr_core_chk.sv
module rptr_core_chk #(
  parameter int NPORT = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPORT-1:0] excl,
  input logic             multi,
  input logic             dv_to,
  input logic [NPORT-1:0] tx_en,
  input logic [3:0]       txd,
  input logic [NPORT-1:0] col_part,
  input logic [1:0]       state_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0) |-> (tx_en == '0 && txd == 4'h0 && col_part == '0));

  assert_fwd_skips_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1) |-> ($countones(tx_en) < NPORT));

  assert_excl_dark_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((tx_en & $past(excl)) == '0));

  assert_multi_col_R4: assert property (@(posedge clk) disable iff (!rst_n)
    multi |=> (state_o == 2'd2 && txd == 4'h5));

  assert_dv_timeout_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dv_to |=> (state_o == 2'd2));

  assert_opl_jam_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd3) |-> (txd == 4'h5 && $countones(tx_en) < NPORT));

  assert_part_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 || state_o == 2'd1) |-> (col_part == '0));
endmodule

bind rptr_core rptr_core_chk #(.NPORT(NPORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .excl(excl), .multi(multi), .dv_to(dv_to),
  .tx_en(tx_en), .txd(txd), .col_part(col_part), .state_o(state_o)
);

// File: tb/tb_rptr_core.sv
module tb_rptr_core;
  localparam int PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  crs = '0, rxdv = '0, jab = '0, iso = '0;
  logic [19:0] rxd = '0;
  logic [4:0]  tx_en, col_part;
  logic [3:0]  txd;
  logic [1:0]  state_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [1:0] st;
    logic [4:0] en;
    logic [3:0] nib;
    logic [4:0] part;
    string      tag;
  } exp_t;
  exp_t q[$];
  exp_t e;

  // reference model state
  int         mst = 0, msrc = 0, mleft = 0, mlow = 0;
  logic [4:0] mpart = '0;

  always #(PER/2) clk = ~clk;

  rptr_core dut (
    .clk(clk), .rst_n(rst_n), .crs(crs), .rxdv(rxdv), .rxd(rxd),
    .jab(jab), .iso(iso), .tx_en(tx_en), .txd(txd),
    .col_part(col_part), .state_o(state_o)
  );

  task automatic cmp(input string tag, input logic [1:0] st, input logic [4:0] en,
                     input logic [3:0] nib, input logic [4:0] part);
    checks++;
    if (state_o !== st || tx_en !== en || txd !== nib || col_part !== part) begin
      errors++;
      $display("FAIL %s: got st=%0d en=%b txd=%h part=%b, want st=%0d en=%b txd=%h part=%b",
               tag, state_o, tx_en, txd, col_part, st, en, nib, part);
    end
  endtask

  // monitor: results are due one edge after the drive
  always begin
    @(posedge clk);
    #(PER/4);
    if (q.size() > 0) begin
      e = q.pop_front();
      cmp(e.tag, e.st, e.en, e.nib, e.part);
    end
  end

  task automatic drive(input logic [4:0] c, input logic [4:0] d, input logic [19:0] r,
                       input logic [4:0] j, input logic [4:0] i, input string tag);
    logic [4:0] a, ok;
    int n, k, nst;
    exp_t x;
    @(negedge clk);
    crs = c; rxdv = d; rxd = r; jab = j; iso = i;
    ok = ~(j | i);
    a = c & ok;
    n = 0; k = 0;
    for (int p = 4; p >= 0; p--) if (a[p]) begin n++; k = p; end
    nst = mst;
    if (mst == 0 || mst == 1) begin
      if (n == 0) nst = 0;
      else if (n > 1) nst = 2;
      else begin
        if (d[k]) mlow = 0;
        else if (mst == 1 && k == msrc) mlow = mlow + 1;
        else mlow = 1;
        if (mlow > 4) nst = 2;
        else begin nst = 1; msrc = k; end
      end
    end else if (mst == 2) begin
      if (n == 0) nst = 0;
      else if (n == 1) begin nst = 3; mleft = k; end
      else nst = 2;
    end else begin
      if (a == (5'b1 << mleft)) nst = 3;
      else if (n == 0) nst = 0;
      else nst = 2;
    end
    if (nst != 1) mlow = 0;
    if (nst == 2) mpart = mpart | a;
    else if (nst != 3) mpart = '0;
    mst = nst;
    x.st = 2'(nst); x.part = mpart; x.tag = tag;
    case (nst)
      1: begin x.en = ok & ~(5'b1 << msrc); x.nib = r[msrc*4 +: 4]; end
      2: begin x.en = ok; x.nib = 4'h5; end
      3: begin x.en = ok & ~(5'b1 << mleft); x.nib = 4'h5; end
      default: begin x.en = '0; x.nib = 4'h0; end
    endcase
    q.push_back(x);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got no end, want end of run");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #(PER/4);
    cmp("R1 reset", 2'd0, 5'b0, 4'h0, 5'b0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(5'b00000, 5'b00000, 20'h12345, 5'b0, 5'b0, "R1 idle");
    drive(5'b00000, 5'b11111, 20'hFFFFF, 5'b0, 5'b0, "R1 idle dv only");
    // single source forwarding
    drive(5'b00100, 5'b00100, 20'h00A00, 5'b0, 5'b0, "R2 fwd p2");
    drive(5'b00100, 5'b00100, 20'h11311, 5'b0, 5'b0, "R2 fwd p2 nib3");
    drive(5'b00100, 5'b00100, 20'h00C00, 5'b0, 5'b0, "R2 fwd p2 nibC");
    drive(5'b00000, 5'b00000, 20'h00000, 5'b0, 5'b0, "R9 fwd to idle");
    // four low dv cycles do not collide
    for (int s = 0; s < 4; s++)
      drive(5'b00001, 5'b00000, 20'h00007, 5'b0, 5'b0, "R5 low dv within limit");
    drive(5'b00001, 5'b00001, 20'h00009, 5'b0, 5'b0, "R5 dv arrives in time");
    drive(5'b00000, 5'b00000, 20'h00000, 5'b0, 5'b0, "R9 idle again");
    // five low dv cycles collide
    for (int s = 0; s < 5; s++)
      drive(5'b10000, 5'b00000, 20'h60000, 5'b0, 5'b0, "R5 dv timeout");
    drive(5'b10000, 5'b00000, 20'h60000, 5'b0, 5'b0, "R6 one left p4");
    drive(5'b00000, 5'b00000, 20'h00000, 5'b0, 5'b0, "R7 opl to idle");
    // two-port collision and one-port-left
    drive(5'b01010, 5'b01010, 20'h0A0B0, 5'b0, 5'b0, "R4 two carriers");
    drive(5'b01010, 5'b01010, 20'h0A0B0, 5'b0, 5'b0, "R8 part held");
    drive(5'b01000, 5'b01000, 20'h0E000, 5'b0, 5'b0, "R6 p3 left");
    drive(5'b01000, 5'b01000, 20'h0E000, 5'b0, 5'b0, "R6 p3 still left");
    drive(5'b01010, 5'b01010, 20'h0E0E0, 5'b0, 5'b0, "R7 opl back to col");
    drive(5'b00010, 5'b00010, 20'h000D0, 5'b0, 5'b0, "R6 p1 left");
    drive(5'b00001, 5'b00001, 20'h0000D, 5'b0, 5'b0, "R7 other port to col");
    drive(5'b00000, 5'b00000, 20'h00000, 5'b0, 5'b0, "R8 part cleared");
    drive(5'b11111, 5'b11111, 20'h00000, 5'b0, 5'b0, "R4 all carriers");
    drive(5'b00000, 5'b00000, 20'h00000, 5'b0, 5'b0, "R1 back to idle");
    // excluded ports
    drive(5'b00100, 5'b00100, 20'h00300, 5'b00100, 5'b0, "R3 jabbered alone");
    drive(5'b00010, 5'b00010, 20'h00040, 5'b0, 5'b00100, "R3 iso skip fwd");
    drive(5'b00110, 5'b00110, 20'h00850, 5'b00100, 5'b0, "R3 jab no col");
    drive(5'b00110, 5'b00110, 20'h00850, 5'b00001, 5'b0, "R3 col masks p0");
    drive(5'b00000, 5'b00000, 20'h00000, 5'b0, 5'b0, "R1 final idle");
    repeat (3) @(posedge clk);
    #(PER/4);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule